// File: doc/BRIEF.md
# Banked RAM/ROM Memory Subsystem

This block gives a processor a 1024-byte memory space on a 16-bit address bus. The lower half of the space is read/write storage split into four 128-byte RAM banks. The upper half is a 512-byte read-only bank whose contents are computed inside the design. Each bank has a pair of selects, one active high and one active low. A bank takes part in a transfer only when its high select is 1 and its low select is 0.

A 2-to-4 decoder on address bits 8:7 drives the high selects of the RAM banks. Address bit 9 splits the space between RAM and ROM. The ROM's low select follows the effective read strobe, so the ROM can only respond to reads. Any address with a nonzero bit in 15:10 lies outside the map. The bidirectional data bus is split into a write-data input, a read-data output and an output-enable, which together model the three-state bus. Writes take effect on the rising clock edge. Reads are combinational from the stored array.

Top module: `mem_subsystem`

## Requirements
- R1: With `rst_n` high, `wr` high and an address in 0..511, the byte on `wdata` is stored at the rising clock edge. A later read of that address returns it.
- R2: With `rd` high, `wr` low and an address in 0..511, `rdata` shows the stored byte and `rdata_oe` is high in the same cycle.
- R3: Address bits 8:7 pick RAM bank 0..3 (00 is bank 0), and bits 6:0 pick the byte within the bank. A write to one bank leaves the same offset in the other banks unchanged.
- R4: With `rd` high, `wr` low and an address in 512..1023, `rdata_oe` is high and `rdata` equals (k*13+7) mod 256, where k is address bits 8:0.
- R5: A write to an address in 512..1023 changes neither the ROM nor any RAM byte.
- R6: An address with any of bits 15:10 nonzero selects no bank. `rdata_oe` stays low, and a write there changes no RAM byte, including the byte at the address's low 9 bits.
- R7: With both `rd` and `wr` low, `rdata_oe` is low for every address.
- R8: With `rd` and `wr` both high, the cycle is a write and `rdata_oe` is low.
- R9: Whenever `rdata_oe` is low, `rdata` is all zeros.
- R10: A write while `rst_n` is low stores nothing.
- R11: At most one bank drives the read bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| addr | input | 16 | Processor address bus |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| wdata | input | 8 | Data from the processor for writes |
| rdata | output | 8 | Data to the processor; zero when not driven |
| rdata_oe | output | 1 | High while some bank drives `rdata` |

## Verification
The bench builds the block with its default parameters: four 128-byte RAM banks, a 512-byte ROM and a 16-bit bus. With these values every RAM byte and every ROM byte can be written and read back in a few thousand cycles. The walk covers both edges of the RAM/ROM split, the alias between in-map and out-of-map addresses that share the low ten bits, and the same offset in all four banks. The reference model treats the map as plain integer ranges (below 512, below 1024). It does not work with decoded bit fields.

// File: rtl/mem_subsystem_pkg.sv
package mem_subsystem_pkg;

  localparam int unsigned DEF_ADDR_W    = 16;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_RAM_AW    = 7;
  localparam int unsigned DEF_RAM_BANKS = 4;

  // ROM image: byte k holds (k*13 + 7) truncated to the data width
  function automatic logic [DEF_DATA_W-1:0] rom_byte(input int unsigned k);
    int unsigned t;
    t = k * 32'd13 + 32'd7;
    return t[DEF_DATA_W-1:0];
  endfunction

  // true when every address bit at or above 'top' is zero
  function automatic logic upper_clear(input logic [DEF_ADDR_W-1:0] a,
                                       input int unsigned top);
    logic ok;
    ok = 1'b1;
    for (int unsigned b = 0; b < DEF_ADDR_W; b++) begin
      if (b >= top && a[b]) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/mem_addr_decode.sv
module mem_addr_decode
  import mem_subsystem_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned RAM_AW    = DEF_RAM_AW,
  parameter int unsigned RAM_BANKS = DEF_RAM_BANKS,
  localparam int unsigned BSEL_W   = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int unsigned SPLIT    = RAM_AW + BSEL_W,
  localparam int unsigned MAP_TOP  = SPLIT + 1
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd_eff,
  output logic [RAM_BANKS-1:0] ram_cs_hi,
  output logic                 ram_cs_lo_n,
  output logic                 rom_cs_hi,
  output logic                 rom_cs_lo_n,
  output logic                 in_map
);

  logic [BSEL_W-1:0] bank_idx;

  assign in_map   = upper_clear(addr, MAP_TOP);
  assign bank_idx = addr[SPLIT-1:RAM_AW];

  // 2-to-N decoder feeding the active-high selects of the RAM banks
  genvar g;
  generate
    for (g = 0; g < RAM_BANKS; g++) begin : g_dec
      assign ram_cs_hi[g] = in_map && (bank_idx == BSEL_W'(g));
    end
  endgenerate

  // split line: drives RAM low selects directly, ROM high select when set
  assign ram_cs_lo_n = addr[SPLIT];
  assign rom_cs_hi   = in_map && addr[SPLIT];
  // ROM low select tied to the read strobe
  assign rom_cs_lo_n = ~rd_eff;

endmodule

// File: rtl/mem_ram_bank.sv
module mem_ram_bank
  import mem_subsystem_pkg::*;
#(
  parameter int unsigned AW    = DEF_RAM_AW,
  parameter int unsigned DW    = DEF_DATA_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_allow,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          drive,
  output logic          write_fire
);

  logic [DW-1:0] cells [DEPTH];
  logic          chip_on;

  assign chip_on    = cs_hi && !cs_lo_n;
  assign write_fire = chip_on && wr && wr_allow;
  assign drive      = chip_on && rd && !wr;
  assign dout       = drive ? cells[addr] : '0;

  always_ff @(posedge clk) begin
    if (write_fire) cells[addr] <= din;
  end

endmodule

// File: rtl/mem_rom_bank.sv
module mem_rom_bank
  import mem_subsystem_pkg::*;
#(
  parameter int unsigned AW    = 9,
  parameter int unsigned DW    = DEF_DATA_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          drive
);

  logic [DW-1:0] image [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_img
      assign image[g] = DW'(rom_byte(g));
    end
  endgenerate

  assign drive = cs_hi && !cs_lo_n;
  assign dout  = drive ? image[addr] : '0;

endmodule

// File: rtl/mem_subsystem.sv
module mem_subsystem
  import mem_subsystem_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned RAM_AW    = DEF_RAM_AW,
  parameter int unsigned RAM_BANKS = DEF_RAM_BANKS,
  localparam int unsigned BSEL_W   = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int unsigned SPLIT    = RAM_AW + BSEL_W,
  localparam int unsigned ROM_AW   = SPLIT,
  localparam int unsigned MAP_TOP  = SPLIT + 1,
  localparam int unsigned NDRV     = RAM_BANKS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  // read and write together resolve to a write with no bus drive
  logic                 rd_eff;
  logic [RAM_BANKS-1:0] ram_cs_hi;
  logic                 ram_cs_lo_n;
  logic                 rom_cs_hi;
  logic                 rom_cs_lo_n;
  logic                 in_map;
  logic [RAM_BANKS-1:0] ram_write_fire;
  logic [NDRV-1:0]      bank_drive;
  logic [DATA_W-1:0]    bank_dout [NDRV];

  assign rd_eff = rd && !wr;

  mem_addr_decode #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .RAM_BANKS(RAM_BANKS)
  ) u_dec (
    .addr(addr), .rd_eff(rd_eff),
    .ram_cs_hi(ram_cs_hi), .ram_cs_lo_n(ram_cs_lo_n),
    .rom_cs_hi(rom_cs_hi), .rom_cs_lo_n(rom_cs_lo_n),
    .in_map(in_map)
  );

  genvar g;
  generate
    for (g = 0; g < RAM_BANKS; g++) begin : g_ram
      mem_ram_bank #(.AW(RAM_AW), .DW(DATA_W)) u_bank (
        .clk(clk), .wr_allow(rst_n),
        .cs_hi(ram_cs_hi[g]), .cs_lo_n(ram_cs_lo_n),
        .rd(rd_eff), .wr(wr),
        .addr(addr[RAM_AW-1:0]), .din(wdata),
        .dout(bank_dout[g]), .drive(bank_drive[g]),
        .write_fire(ram_write_fire[g])
      );
    end
  endgenerate

  mem_rom_bank #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
    .cs_hi(rom_cs_hi), .cs_lo_n(rom_cs_lo_n),
    .addr(addr[ROM_AW-1:0]),
    .dout(bank_dout[RAM_BANKS]), .drive(bank_drive[RAM_BANKS])
  );

  // wired-OR of the bank outputs; idle banks return zero
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NDRV; i++) rdata = rdata | bank_dout[i];
  end

  assign rdata_oe = |bank_drive;

endmodule

// File: rtl/mem_subsystem_chk.sv
module mem_subsystem_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RAM_AW    = 7,
  parameter int unsigned RAM_BANKS = 4,
  parameter int unsigned SPLIT     = 9,
  parameter int unsigned MAP_TOP   = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 rd,
  input logic                 wr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic                 rdata_oe,
  input logic [RAM_BANKS:0]   bank_drive,
  input logic [RAM_BANKS-1:0] ram_write_fire
);

  logic outside;
  assign outside = (addr >> MAP_TOP) != '0;

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ram_write_fire) != '0) && rd && !wr && addr == $past(addr))
      |-> rdata == $past(wdata));

  assert_bank_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_write_fire != '0) |-> ($onehot(ram_write_fire) && ram_write_fire[addr[SPLIT-1:RAM_AW]]));

  assert_rom_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !outside && addr[SPLIT]) |-> rdata_oe);

  assert_rom_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr[SPLIT] |-> ram_write_fire == '0);

  assert_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (!rdata_oe && ram_write_fire == '0));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |-> !rdata_oe);

  assert_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !rdata_oe);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);

  assert_one_driver_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_drive));

  always @(posedge clk) begin
    if (!rst_n) assert_reset_hold_R10: assert (ram_write_fire == '0);
  end

endmodule

bind mem_subsystem mem_subsystem_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .RAM_BANKS(RAM_BANKS),
  .SPLIT(SPLIT), .MAP_TOP(MAP_TOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
  .rdata(rdata), .rdata_oe(rdata_oe), .bank_drive(bank_drive),
  .ram_write_fire(ram_write_fire)
);

// File: tb/mem_subsystem_test.sv
module mem_subsystem_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [7:0] ram_m [512];

  always #5 clk = ~clk;

  mem_subsystem uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [7:0] rom_ref(input int k);
    return 8'((k * 13 + 7) % 256);
  endfunction

  function automatic logic [7:0] fill_val(input int a);
    return 8'((a * 29 + 101) % 256);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // one bus cycle: drive, compare against model mid-cycle, update model at edge
  task automatic step(input int a, input logic r, input logic w,
                      input logic [7:0] d, input string tag);
    logic       e_oe;
    logic [7:0] e_dat;
    addr = 16'(a); rd = r; wr = w; wdata = d;
    #2;
    e_oe = 1'b0; e_dat = 8'h00;
    if (r && !w && a < 1024) begin
      e_oe  = 1'b1;
      e_dat = (a < 512) ? ram_m[a] : rom_ref(a - 512);
    end
    compared++;
    if (rdata_oe !== e_oe || rdata !== e_dat) begin
      mismatched++;
      $display("FAIL %s addr=%h rd=%0b wr=%0b: got oe=%0b data=%h, expected oe=%0b data=%h",
               tag, a, r, w, rdata_oe, rdata, e_oe, e_dat);
    end
    @(posedge clk);
    if (w && rst_n && a < 512) ram_m[a] = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) ram_m[i] = 8'h00;
    @(negedge clk);
    // reset state: nothing drives the bus
    step(0, 1'b0, 1'b0, 8'h00, "R7 reset");
    step(700, 1'b0, 1'b0, 8'h00, "R9 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // fill all RAM, then read everything back
    for (int a = 0; a < 512; a++) step(a, 1'b0, 1'b1, fill_val(a), "R1 fill");
    for (int a = 0; a < 512; a++) step(a, 1'b1, 1'b0, 8'h00, "R2 R3 readback");
    // whole ROM
    for (int a = 512; a < 1024; a++) step(a, 1'b1, 1'b0, 8'h00, "R4 rom");

    // R5: write into ROM region, ROM and aliased RAM unchanged
    step(600, 1'b0, 1'b1, 8'h5A, "R5 rom write");
    step(600, 1'b1, 1'b0, 8'h00, "R5 rom intact");
    step(88, 1'b1, 1'b0, 8'h00, "R5 ram alias intact");
    step(1023, 1'b0, 1'b1, 8'hA5, "R5 rom write top");
    step(511, 1'b1, 1'b0, 8'h00, "R5 ram top intact");

    // R6: out of map
    step(16'h0405, 1'b1, 1'b0, 8'h00, "R6 read bit10");
    step(16'hFFFF, 1'b1, 1'b0, 8'h00, "R6 read all ones");
    step(16'h0805, 1'b0, 1'b1, 8'h11, "R6 write outside");
    step(16'h8005, 1'b0, 1'b1, 8'h22, "R6 write bit15");
    step(5, 1'b1, 1'b0, 8'h00, "R6 alias intact");

    // R8: read and write together
    step(10, 1'b1, 1'b1, 8'hC3, "R8 rd+wr");
    step(10, 1'b1, 1'b0, 8'h00, "R8 R1 stored");
    step(700, 1'b1, 1'b1, 8'h77, "R8 rd+wr rom");

    // R10: write during reset ignored
    rst_n = 1'b0;
    step(20, 1'b0, 1'b1, 8'hEE, "R10 write in reset");
    rst_n = 1'b1;
    step(20, 1'b1, 1'b0, 8'h00, "R10 intact");

    // R3: same offset in each bank stays independent
    step(16'h005, 1'b0, 1'b1, 8'h12, "R3 write bank0");
    step(16'h085, 1'b1, 1'b0, 8'h00, "R3 bank1");
    step(16'h105, 1'b1, 1'b0, 8'h00, "R3 bank2");
    step(16'h185, 1'b1, 1'b0, 8'h00, "R3 bank3");
    step(16'h185, 1'b0, 1'b1, 8'h34, "R3 write bank3");
    step(16'h005, 1'b1, 1'b0, 8'h00, "R3 bank0");
    step(16'h185, 1'b1, 1'b0, 8'h00, "R3 R11 bank3");

    // R7 / R9: idle with addresses in each region
    step(300, 1'b0, 1'b0, 8'hFF, "R7 idle ram");
    step(900, 1'b0, 1'b0, 8'hFF, "R7 R9 idle rom");
    // boundary around the split
    step(511, 1'b1, 1'b0, 8'h00, "R2 split low");
    step(512, 1'b1, 1'b0, 8'h00, "R4 R11 split high");

    finish_run();
  end

endmodule